// File: doc/BRIEF.md
# Triggered Multi-Frame Capture Gate

This block sits on a continuous stream of complex samples and opens a capture window when a trigger arrives. The window carries a programmable number of back-to-back frames of fixed length. Once the last sample of the last frame has been delivered, the window closes, a one-cycle completion pulse is raised, and the block returns to idle. While the window is shut, the output stream shows no valid beats and its data bus is held at zero. Samples arriving in that time are accepted and discarded, so the upstream source never stalls.

Both stream edges use valid/ready handshakes. A beat moves on the input side when `s_valid_i` and `s_ready_o` are both high. While the window is open, the input is passed straight through to the output and back-pressure is carried straight back: `s_ready_o` equals `m_ready_i`, and a beat counts only when the downstream side takes it. While the window is shut, `s_ready_o` is held high and nothing is presented downstream.

The frame count is sampled from a register input when the trigger is accepted. Writing a new value during a capture does not change that capture. Each output beat is marked as the first or the last sample of its frame. The frame length defaults to 512 samples and each complex sample is one 32-bit word.

Top module: `frame_window_capture`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `m_valid_o`, `m_sof_o` and `m_eof_o` are 0, `m_data_o` is 0 and `s_ready_o` is 1.
- R2: While no window is open (idle, or the completion cycle), `m_valid_o`, `m_sof_o` and `m_eof_o` are 0, `m_data_o` is all zeros and `s_ready_o` is 1, whatever `s_valid_i` and `s_data_i` do.
- R3: A one-cycle high on `trig_i` while idle opens the window from the next cycle on, with `busy_o` = 1. The block then waits for the first input beat.
- R4: Accepted beats are numbered from 0 within the window. `m_sof_o` is 1 on each beat whose index modulo FRAME_LEN is 0. `m_eof_o` is 1 on each beat whose index modulo FRAME_LEN is FRAME_LEN-1.
- R5: A window carries exactly N×FRAME_LEN accepted beats, where N is the frame count latched at the trigger. The window closes in the cycle after the last of these beats.
- R6: A frame count of 0 is handled as 1.
- R7: Changes on `cfg_frames_i` after the trigger cycle have no effect on the running capture.
- R8: `trig_i` is ignored while `busy_o` is 1 and in the completion cycle.
- R9: In the cycle after the final beat, `done_o` = 1 and `busy_o` = 0. In the cycle after that, `done_o` = 0.
- R10: While the window is open, `m_valid_o` = `s_valid_i`, `m_data_o` = `s_data_i` and `s_ready_o` = `m_ready_i`. Beat positions advance only on cycles where both `s_valid_i` and `m_ready_i` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Capture trigger, sampled while idle |
| cfg_frames_i | input | FC_W | Frames per capture (0 handled as 1) |
| s_data_i | input | DATA_W | Input complex sample |
| s_valid_i | input | 1 | Input sample valid |
| s_ready_o | output | 1 | Input ready |
| m_data_o | output | DATA_W | Gated sample, zero when the window is shut |
| m_valid_o | output | 1 | Output valid |
| m_ready_i | input | 1 | Downstream ready |
| m_sof_o | output | 1 | First sample of a frame |
| m_eof_o | output | 1 | Last sample of a frame |
| busy_o | output | 1 | Window open (armed or capturing) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every frame count, including 0, with a small frame length. It uses three stream patterns:
- valid and ready held high, which pins down the exact beat count and the frame marker positions;
- valid present on alternate cycles, which shows that idle input cycles do not advance the position;
- an irregular mix of valid and ready gaps, which separates a transfer from mere presence of data.

Each capture also changes the register value and pulses the trigger in the middle of the window, so a wrongly re-latched count or a restarted window shows up as a wrong beat total. Checks in idle and in the completion cycle confirm that inputs pass nothing while the window is shut.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } fwc_state_e;
endpackage

// File: rtl/fwc_position.sv
module fwc_position #(
  parameter int FRAME_LEN = 512,
  parameter int FC_W      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            step,
  input  logic [FC_W-1:0] frames_target,
  output logic            first_in_frame,
  output logic            last_in_frame,
  output logic            last_frame
);
  localparam int SW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [SW-1:0] LAST_IDX = SW'(FRAME_LEN - 1);

  logic [SW-1:0]   samp_idx;
  logic [FC_W-1:0] frame_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_idx  <= '0;
      frame_idx <= '0;
    end else if (clear) begin
      samp_idx  <= '0;
      frame_idx <= '0;
    end else if (step) begin
      if (last_in_frame) begin
        samp_idx  <= '0;
        frame_idx <= frame_idx + 1'b1;
      end else begin
        samp_idx <= samp_idx + 1'b1;
      end
    end
  end

  always_comb begin
    first_in_frame = (samp_idx == '0);
    last_in_frame  = (samp_idx == LAST_IDX);
    last_frame     = (frame_idx == frames_target - 1'b1);
  end

  AST_SAMP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && last_in_frame) |=> first_in_frame); // R4

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> ($stable(samp_idx) && $stable(frame_idx))); // R10
endmodule

// File: rtl/fwc_sequencer.sv
module fwc_sequencer
  import fwc_pkg::*;
#(
  parameter int FC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic [FC_W-1:0] cfg_frames,
  input  logic            beat,
  input  logic            last_in_frame,
  input  logic            last_frame,
  output fwc_state_e      state,
  output logic [FC_W-1:0] frames_q,
  output logic            start,
  output logic            window_open
);
  logic final_beat;

  always_comb begin
    start       = (state == ST_IDLE) && trig;
    window_open = (state == ST_ARMED) || (state == ST_CAPT);
    final_beat  = beat && last_in_frame && last_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      frames_q <= FC_W'(1);
    end else begin
      case (state)
        ST_IDLE: begin
          if (trig) begin
            state    <= ST_ARMED;
            frames_q <= (cfg_frames == '0) ? FC_W'(1) : cfg_frames;
          end
        end
        ST_ARMED: begin
          if (final_beat)  state <= ST_DONE;
          else if (beat)   state <= ST_CAPT;
        end
        ST_CAPT: begin
          if (final_beat)  state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (frames_q != '0)); // R6

  AST_COUNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(frames_q)); // R7

  AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAPT && trig && !beat) |=> (state == ST_CAPT)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_IDLE)); // R9
endmodule

// File: rtl/fwc_gate.sv
module fwc_gate #(
  parameter int DATA_W = 32
) (
  input  logic              window_open,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              m_ready,
  input  logic              first_in_frame,
  input  logic              last_in_frame,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  output logic              m_sof,
  output logic              m_eof,
  output logic              s_ready,
  output logic              beat
);
  always_comb begin
    m_valid = window_open && s_valid;
    m_data  = window_open ? s_data : '0;
    m_sof   = m_valid && first_in_frame;
    m_eof   = m_valid && last_in_frame;
    s_ready = window_open ? m_ready : 1'b1;
    beat    = m_valid && m_ready;
  end
endmodule

// File: rtl/frame_window_capture.sv
module frame_window_capture
  import fwc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int FRAME_LEN = 512,
  parameter int FC_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [FC_W-1:0]   cfg_frames_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic              m_sof_o,
  output logic              m_eof_o,
  output logic              busy_o,
  output logic              done_o
);
  fwc_state_e      state;
  logic [FC_W-1:0] frames_q;
  logic            start;
  logic            window_open;
  logic            beat;
  logic            first_in_frame;
  logic            last_in_frame;
  logic            last_frame;

  fwc_sequencer #(.FC_W(FC_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig          (trig_i),
    .cfg_frames    (cfg_frames_i),
    .beat          (beat),
    .last_in_frame (last_in_frame),
    .last_frame    (last_frame),
    .state         (state),
    .frames_q      (frames_q),
    .start         (start),
    .window_open   (window_open)
  );

  fwc_position #(.FRAME_LEN(FRAME_LEN), .FC_W(FC_W)) u_pos (
    .clk            (clk),
    .rst_n          (rst_n),
    .clear          (start),
    .step           (beat),
    .frames_target  (frames_q),
    .first_in_frame (first_in_frame),
    .last_in_frame  (last_in_frame),
    .last_frame     (last_frame)
  );

  fwc_gate #(.DATA_W(DATA_W)) u_gate (
    .window_open    (window_open),
    .s_data         (s_data_i),
    .s_valid        (s_valid_i),
    .m_ready        (m_ready_i),
    .first_in_frame (first_in_frame),
    .last_in_frame  (last_in_frame),
    .m_data         (m_data_o),
    .m_valid        (m_valid_o),
    .m_sof          (m_sof_o),
    .m_eof          (m_eof_o),
    .s_ready        (s_ready_o),
    .beat           (beat)
  );

  always_comb begin
    busy_o = window_open;
    done_o = (state == ST_DONE);
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!m_valid_o && m_data_o == '0 && s_ready_o)); // R2

  AST_TRIG_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o && trig_i) |=> busy_o); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R9

  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i) |-> !s_ready_o); // R10

  AST_MARKS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_sof_o, m_eof_o}) || FRAME_LEN == 1); // R4
endmodule

// File: tb/frame_window_capture_tb.sv
module frame_window_capture_tb;
  localparam int DW = 32;
  localparam int L  = 8;
  localparam int FW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0;
  logic [FW-1:0] cfg = '0;
  logic [DW-1:0] s_data = '0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] m_data;
  logic          m_valid;
  logic          m_ready = 1'b1;
  logic          m_sof;
  logic          m_eof;
  logic          busy;
  logic          done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  frame_window_capture #(.DATA_W(DW), .FRAME_LEN(L), .FC_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .cfg_frames_i(cfg),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_ready_o(s_ready),
    .m_data_o(m_data), .m_valid_o(m_valid), .m_ready_i(m_ready),
    .m_sof_o(m_sof), .m_eof_o(m_eof), .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_probe();
    @(negedge clk);
    s_valid = 1'b1; s_data = 32'hA5A5_0001; m_ready = 1'b0;
    #1;
    check(!m_valid && !m_sof && !m_eof, "R2 valid/marks", {m_valid, m_sof, m_eof}, 0);
    check(m_data == '0, "R2 data zero", m_data, 0);
    check(s_ready, "R2 ready high", s_ready, 1);
    m_ready = 1'b1;
  endtask

  task automatic run_capture(input int n_cfg, input int mode);
    int eff;
    int beats;
    int cyc;
    bit closed;
    logic [DW-1:0] word;
    eff    = (n_cfg == 0) ? 1 : n_cfg;
    beats  = 0;
    cyc    = 0;
    closed = 0;
    word   = 32'h1000 * (n_cfg + 1) + mode * 32'h100;
    @(negedge clk);
    trig = 1'b1; cfg = FW'(n_cfg); s_valid = 1'b0;
    @(negedge clk);
    trig = 1'b0; cfg = FW'(n_cfg + 3);  // R7: register change after trigger
    check(busy, "R3 busy after trigger", busy, 1);
    while (!closed && cyc < 2000) begin
      if (!busy) begin
        check(done, "R9 done pulse", done, 1);
        check(beats == eff * L, (n_cfg == 0) ? "R6 beat total" : "R5 beat total",
              beats, eff * L);
        s_valid = 1'b1; s_data = 32'hDEAD;
        #1;
        check(!m_valid && m_data == '0, "R2 closed in done cycle", m_valid, 0);
        trig = 1'b1;  // R8: trigger in completion cycle
        @(negedge clk);
        trig = 1'b0;
        check(!done && !busy, "R9 done drops, R8 no restart", {done, busy}, 0);
        closed = 1;
      end else begin
        trig = (cyc == 5);  // R8: trigger mid-window
        case (mode)
          0: begin s_valid = 1'b1; m_ready = 1'b1; end
          1: begin s_valid = cyc[0]; m_ready = 1'b1; end
          default: begin s_valid = (cyc % 3) != 0; m_ready = (cyc % 5) != 2; end
        endcase
        s_data = word;
        #1;
        check(m_valid == s_valid && s_ready == m_ready, "R10 pass-through",
              {m_valid, s_ready}, {s_valid, m_ready});
        if (m_valid && m_ready) begin
          check(m_data == word, "R10 data", m_data, word);
          check(m_sof == ((beats % L) == 0), "R4 sof", m_sof, (beats % L) == 0);
          check(m_eof == ((beats % L) == L - 1), "R4 eof", m_eof, (beats % L) == L - 1);
          beats++;
        end
        word = word + 1;
        cyc++;
        @(negedge clk);
        trig = 1'b0;
      end
    end
    if (!closed) check(0, "R5 window never closed", 0, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #3;
    check(!busy && !done && !m_valid && !m_sof && !m_eof, "R1 reset outputs",
          {busy, done, m_valid, m_sof, m_eof}, 0);
    check(m_data == '0 && s_ready, "R1 reset data/ready", {m_data[30:0], s_ready}, 1);
    #20;
    rst_n = 1'b1;
    idle_probe();
    for (int mode = 0; mode < 3; mode++) begin
      for (int n = 0; n < (1 << FW); n++) begin
        run_capture(n, mode);
        idle_probe();
      end
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule